// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a 4K x 8 serial memory. It watches the two-wire clock and data lines through a synchronizer on a fast system clock and finds the START and STOP conditions. It receives bytes MSB first and answers on the data line through an open-drain style enable, where a 1 pulls the line low. After a START, the first byte is checked against a fixed type code and three strap inputs. A write command then takes two address bytes, which load a pointer, and then any number of data bytes. Each data byte is handed to an external write cache together with its address. A STOP at a byte boundary tells the cache to start its internal write cycle.

A read command streams array bytes starting at the pointer. The bytes are fetched from a synchronous RAM port with one cycle of latency, one byte ahead of the bus. While the cache reports a write cycle in progress, the engine acknowledges nothing, so the master can poll the device by sending control bytes until one of them is acknowledged. The pointer is 16 bits wide and keeps counting past the top of the array. Bytes read beyond the array return 0xFF.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), no write strobes are issued, and the pointer is 0, so a current-address read returns the byte at address 0x000.
- R2: A control byte whose upper four bits are 1010 and whose bits 3..1 equal `dev_sel` is acknowledged: `sda_oe` is 1 while SCL is high on the ninth clock. Bit 0 of the control byte selects read (1) or write (0).
- R3: A control byte with a different type code or select value is not acknowledged. The engine then leaves the line released and ignores every byte until the next START, and the pointer is not changed.
- R4: While `wr_busy` is 1, no byte is acknowledged, including a matching control byte. Once `wr_busy` is 0, the same control byte is acknowledged again.
- R5: After a write control byte, the next two bytes load the pointer high byte and low byte. Bits 7..4 of the high byte are forced to zero. Each data byte that follows gives a one-cycle `wr_valid` with `wr_addr` equal to the pointer, and the pointer then advances by one.
- R6: A STOP at a byte boundary after at least one data byte gives exactly one `wr_commit` pulse. A STOP after only the address bytes gives none.
- R7: A STOP or START that arrives after two or more data bits of a byte aborts the transfer: no `wr_commit` is issued for it.
- R8: Random read: a write control byte, two address bytes, a repeated START and a read control byte return the byte at the loaded address.
- R9: A current-address read returns the byte that follows the last byte written or read.
- R10: In a read, a master ACK (SDA low on the ninth clock) makes the engine send the next address. A master NACK releases the line for all further clocks until the next START or STOP.
- R11: The pointer counts on from 0x0FFF to 0x1000 without wrapping. Any byte read from an address of 0x1000 or above is 0xFF.
- R12: `sda_oe` changes only while SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 3 | Strap value that the control byte select bits must match |
| wr_busy | input | 1 | Internal write cycle in progress |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | 12 | Array read address |
| rd_data | input | 8 | Array read data, valid one cycle after `rd_en` |
| wr_valid | output | 1 | One-cycle strobe: a data byte for the write cache |
| wr_addr | output | 12 | Address of the cached byte |
| wr_data | output | 8 | Cached byte value |
| wr_commit | output | 1 | One-cycle strobe: start the internal write cycle |

## Verification
The hardest situations to reach are the aborts: a STOP or repeated START that falls in the middle of a byte, after the pointer and the cache have already taken earlier data bytes. The bench drives the lines bit by bit. It breaks off a data byte after a few bits and then either counts commit pulses or follows the abort with a read that shows where the pointer stands. The pointer overflow is reached by loading 0x0FFF and reading sequentially across the end of the array. Acknowledge polling is reached by holding `wr_busy` high across whole transactions.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int ADDR_W = 12;
  localparam int PTR_W  = 16;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } state_t;

  // Next pointer value: a plain increment, never wrapping at the array top.
  function automatic ptr_t ptr_advance(ptr_t p);
    return p + ptr_t'(1);
  endfunction

  // True when the address falls inside the populated array.
  function automatic logic in_array(ptr_t p);
    return p < ptr_t'(1 << ADDR_W);
  endfunction

  // High address byte with the unused upper bits forced to zero.
  function automatic logic [PTR_W-9:0] hi_load(logic [7:0] b);
    logic [PTR_W-9:0] r;
    r = '0;
    r[ADDR_W-9:0] = b[ADDR_W-9:0];
    return r;
  endfunction

  // Control byte acceptance: type code and strap select.
  function automatic logic ctrl_hit(logic [7:0] b, logic [2:0] sel, logic [3:0] code);
    return (b[7:4] == code) && (b[3:1] == sel);
  endfunction
endpackage

// File: rtl/sm_line_sense.sv
module sm_line_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sm_addr_ptr.sv
module sm_addr_ptr
  import sm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_hi,
  input  logic       ld_lo,
  input  logic       inc,
  input  logic [7:0] din,
  output ptr_t       ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (ld_hi) ptr[PTR_W-1:8] <= hi_load(din);
    else if (ld_lo) ptr[7:0] <= din;
    else if (inc)   ptr <= ptr_advance(ptr);
  end

  assert_hi_nibble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> ptr[PTR_W-1:ADDR_W] == '0);

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo && ptr == ptr_t'((1 << ADDR_W) - 1)) |=> ptr[ADDR_W]);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import sm_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;

  sm_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  state_t     state;
  logic [3:0] cnt;
  logic [7:0] shreg, hold;
  logic       oe_q, mack, got_data;
  logic       fetch_req, fetch_pend, fetch_pop;
  ptr_t       fetch_addr, ptr;

  // Named bus events inside a byte frame.
  logic rx_state, ack_slot, frame_end, ctrl_ok, load_byte, ld_hi, ld_lo, inc;
  assign rx_state  = (state == ST_CTRL) || (state == ST_AHI) ||
                     (state == ST_ALO)  || (state == ST_WDAT);
  assign ack_slot  = rx_state && ev_fall && (cnt == 4'd8);
  assign frame_end = ev_fall && (cnt == 4'd9);
  assign ctrl_ok   = ctrl_hit(shreg, dev_sel, TYPE_CODE) && !wr_busy;
  assign load_byte = !ev_start && !ev_stop && frame_end &&
                     ((state == ST_CTRL && shreg[0]) || (state == ST_RDAT && mack));
  assign ld_hi     = !ev_start && !ev_stop && ack_slot && (state == ST_AHI);
  assign ld_lo     = !ev_start && !ev_stop && ack_slot && (state == ST_ALO);
  assign inc       = (!ev_start && !ev_stop && ack_slot && (state == ST_WDAT)) || load_byte;

  sm_addr_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(inc),
    .din(shreg), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  hold <= 8'hFF;
      oe_q <= 1'b0;  mack <= 1'b0;  got_data <= 1'b0;
      fetch_req <= 1'b0;  fetch_pend <= 1'b0;  fetch_pop <= 1'b0;  fetch_addr <= '0;
      wr_valid <= 1'b0;  wr_addr <= '0;  wr_data <= '0;  wr_commit <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      wr_commit  <= 1'b0;
      fetch_req  <= 1'b0;
      fetch_pend <= fetch_req;
      if (fetch_req)  fetch_pop <= in_array(fetch_addr);
      if (fetch_pend) hold <= fetch_pop ? rd_data : 8'hFF;

      if (ev_start) begin
        state <= ST_CTRL;  cnt <= '0;  oe_q <= 1'b0;  got_data <= 1'b0;
      end else if (ev_stop) begin
        wr_commit <= (state == ST_WDAT) && got_data && (cnt <= 4'd1);
        state <= ST_IDLE;  cnt <= '0;  oe_q <= 1'b0;  got_data <= 1'b0;
      end else if (state == ST_RDAT) begin
        if (ev_rise) begin
          if (cnt == 4'd8) begin
            cnt  <= 4'd9;
            mack <= !sda_s;
          end else cnt <= cnt + 4'd1;
        end else if (ev_fall) begin
          if (cnt == 4'd9) begin
            if (mack) begin
              shreg <= hold;  oe_q <= !hold[7];  cnt <= '0;
              fetch_req <= 1'b1;  fetch_addr <= ptr_advance(ptr);
            end else begin
              oe_q <= 1'b0;  state <= ST_IDLE;
            end
          end else if (cnt == 4'd8) begin
            oe_q <= 1'b0;
          end else begin
            shreg <= {shreg[6:0], 1'b0};
            oe_q  <= !shreg[6];
          end
        end
      end else if (rx_state) begin
        if (ev_rise && cnt != 4'd9) begin
          if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (ack_slot) begin
          case (state)
            ST_CTRL: begin
              if (!ctrl_ok) state <= ST_IDLE;
              else begin
                oe_q <= 1'b1;
                if (shreg[0]) begin
                  fetch_req <= 1'b1;  fetch_addr <= ptr;
                end
              end
            end
            ST_WDAT: begin
              oe_q <= !wr_busy;  wr_valid <= 1'b1;  got_data <= 1'b1;
              wr_addr <= ptr[ADDR_W-1:0];  wr_data <= shreg;
            end
            default: oe_q <= !wr_busy;
          endcase
        end
        if (frame_end) begin
          oe_q <= 1'b0;
          cnt  <= '0;
          case (state)
            ST_CTRL: begin
              if (shreg[0]) begin
                state <= ST_RDAT;  shreg <= hold;  oe_q <= !hold[7];
                fetch_req <= 1'b1;  fetch_addr <= ptr_advance(ptr);
              end else state <= ST_AHI;
            end
            ST_AHI:  state <= ST_ALO;
            default: state <= ST_WDAT;
          endcase
        end
      end
    end
  end

  assign sda_oe  = oe_q;
  assign rd_en   = fetch_req;
  assign rd_addr = fetch_addr[ADDR_W-1:0];

  assert_busy_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && wr_busy && !ev_start && !ev_stop) |=> !sda_oe);

  assert_bad_select_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && state == ST_CTRL && shreg[3:1] != dev_sel && !ev_start && !ev_stop)
      |=> (!sda_oe && state == ST_IDLE));

  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop));

  assert_abort_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && cnt > 4'd1) |=> !wr_commit);

  assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(ev_start || ev_stop)));
endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_busy = 1'b0;
  logic [2:0] dev_sel = 3'b101;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, rd_en, wr_valid, wr_commit;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  wire bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  eeprom_i2c_slave i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .wr_busy(wr_busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit)
  );

  function automatic logic [7:0] memf(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'h5};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memf(rd_addr);

  int checks = 0, errors = 0, nwr = 0, ncommit = 0, oe_viol = 0;
  logic [11:0] ev_addr [16];
  logic [7:0]  ev_data [16];
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (wr_valid && nwr < 16) begin
      ev_addr[nwr] <= wr_addr;
      ev_data[nwr] <= wr_data;
    end
    if (wr_valid) nwr <= nwr + 1;
    if (wr_commit) ncommit <= ncommit + 1;
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bitx(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q/2); s = bus; tick(Q/2); scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(b[i], s);
    bitx(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, s);
      b[i] = s;
    end
    bitx(~mack, s);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start(); send_byte(8'hAA, a); send_byte(hi, a); send_byte(lo, a);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    check("R1 sda released", sda_oe, 1'b0);
    check("R1 no write strobes", nwr, 0);
    bus_start(); send_byte(8'hAB, a);
    check("R2 read control ack", a, 1'b1);
    recv_byte(1'b0, d);
    check("R1 pointer zero", d, memf(12'h000));
    bus_stop();
  endtask

  task automatic t_write();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAA, a);
    check("R2 write control ack", a, 1'b1);
    send_byte(8'hF3, a); send_byte(8'h45, a);
    send_byte(8'h11, a); check("R5 data ack", a, 1'b1);
    send_byte(8'h22, a);
    bus_stop(); tick(4);
    check("R5 strobe count", nwr, 2);
    check("R5 first addr nibble forced", ev_addr[0], 12'h345);
    check("R5 first data", ev_data[0], 8'h11);
    check("R5 second addr", ev_addr[1], 12'h346);
    check("R5 second data", ev_data[1], 8'h22);
    check("R6 one commit", ncommit, 1);
    bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d);
    check("R9 current read after write", d, memf(12'h347));
    bus_stop();
  endtask

  task automatic t_reads();
    logic a; logic [7:0] d;
    set_addr(8'h01, 8'h20); bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d);
    check("R8 random read", d, memf(12'h120));
    bus_stop();
    set_addr(8'h01, 8'hFE); bus_start(); send_byte(8'hAB, a);
    recv_byte(1'b1, d); check("R10 seq byte 0", d, memf(12'h1FE));
    recv_byte(1'b1, d); check("R10 seq byte 1", d, memf(12'h1FF));
    recv_byte(1'b0, d); check("R10 seq byte 2", d, memf(12'h200));
    recv_byte(1'b0, d); check("R10 released after nack", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hA2, a);
    check("R3 wrong select no ack", a, 1'b0);
    send_byte(8'h00, a); check("R3 later byte ignored", a, 1'b0);
    bus_stop();
    bus_start(); send_byte(8'hBA, a);
    check("R3 wrong type no ack", a, 1'b0);
    bus_stop();
    bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d);
    check("R3 pointer untouched", d, memf(12'h201));
    bus_stop();
  endtask

  task automatic t_busy();
    logic a; logic [7:0] d; int c0;
    c0 = ncommit;
    wr_busy = 1'b1;
    bus_start(); send_byte(8'hAA, a); check("R4 busy write poll no ack", a, 1'b0); bus_stop();
    bus_start(); send_byte(8'hAB, a); check("R4 busy read no ack", a, 1'b0); bus_stop();
    wr_busy = 1'b0;
    set_addr(8'h00, 8'h30); bus_stop(); tick(4);
    check("R6 no commit after address only", ncommit, c0);
    bus_start(); send_byte(8'hAB, a);
    check("R4 ack after busy clears", a, 1'b1);
    recv_byte(1'b0, d); check("R8 pointer from address only", d, memf(12'h030));
    bus_stop();
  endtask

  task automatic t_abort();
    logic a, s; logic [7:0] d; int c0, n0;
    c0 = ncommit; n0 = nwr;
    set_addr(8'h00, 8'h10); send_byte(8'h55, a);
    bitx(1'b1, s); bitx(1'b0, s); bitx(1'b1, s);
    bus_stop(); tick(4);
    check("R7 stop mid byte no commit", ncommit, c0);
    check("R7 earlier byte still cached", nwr, n0 + 1);
    set_addr(8'h00, 8'h10); send_byte(8'h66, a);
    bitx(1'b0, s); bitx(1'b1, s);
    bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d);
    check("R7 start mid byte keeps pointer", d, memf(12'h011));
    bus_stop(); tick(4);
    check("R7 start mid byte no commit", ncommit, c0);
  endtask

  task automatic t_overflow();
    logic a; logic [7:0] d;
    set_addr(8'h0F, 8'hFF); bus_start(); send_byte(8'hAB, a);
    recv_byte(1'b1, d); check("R11 last array byte", d, memf(12'hFFF));
    recv_byte(1'b0, d); check("R11 beyond array", d, 8'hFF);
    bus_stop();
    bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d);
    check("R11 no wrap to zero", d, 8'hFF);
    bus_stop();
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_write();
    t_reads();
    t_mismatch();
    t_busy();
    t_abort();
    t_overflow();
    tick(10);
    check("R12 sda_oe changes under SCL high", oe_viol, 0);
    report();
  end
endmodule